// File: doc/BRIEF.md
# Saturating Vector-Scalar Add/Subtract Unit

This block performs element-wise saturating arithmetic between a packed vector of SEW-bit elements and a single SEW-bit scalar shared by every element. Four operations are offered: unsigned add, signed add, unsigned subtract and signed subtract. Each element is computed one bit wider than SEW, so an overflow is seen and clamped to the nearest representable value instead of wrapping.

A per-element enable mask chooses which elements receive a new result. Elements whose enable bit is low pass the prior destination value through unchanged. A single flag reports that at least one enabled element was clamped. The arithmetic is combinational, and the merged vector and the flag are captured in one register stage. The outputs therefore show the result of the inputs presented one clock earlier.

Top module: `vsat_addsub`

## Requirements
- R1: With op_i = 2'b00 (unsigned add), an enabled element gets elem + scalar when the sum fits in SEW bits. If it does not fit, the element gets all ones.
- R2: With op_i = 2'b01 (signed add), an enabled element gets the two's-complement sum, clamped to the range [-2^(SEW-1), 2^(SEW-1)-1].
- R3: With op_i = 2'b10 (unsigned subtract), an enabled element gets zero when elem < scalar, and elem - scalar otherwise.
- R4: With op_i = 2'b11 (signed subtract), an enabled element gets the two's-complement difference, clamped to the signed SEW range.
- R5: Both subtract forms compute the vector element minus the scalar, never the scalar minus the element.
- R6: An element whose mask_i bit is 0 takes the value of the same element of old_i, whatever the operation or operands.
- R7: sat_o is 1 exactly when at least one element with its mask_i bit set was clamped. Clamping on an element with its mask bit clear does not set sat_o.
- R8: Element i occupies bits [i*SEW +: SEW] of vec_i, old_i and res_o. The outputs reflect the inputs sampled at the previous rising clk edge. While rst_n is low, res_o and sat_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_i | input | NELEM*SEW | Packed vector operand elements |
| old_i | input | NELEM*SEW | Prior destination elements, kept where the mask bit is clear |
| scalar_i | input | SEW | Scalar operand shared by all elements |
| op_i | input | 2 | Operation select: 00 addu, 01 add, 10 subu, 11 sub |
| mask_i | input | NELEM | Per-element enable |
| res_o | output | NELEM*SEW | Registered result vector |
| sat_o | output | 1 | Registered flag: an enabled element was clamped |

## Verification
The bench builds the unit with SEW = 8 and NELEM = 4. At this width the clamp limits 0, 255, -128 and 127 can be reached directly with directed operands. Random operands also cross the overflow boundary often. Four lanes allow mixed masks, so clamping in a disabled lane can be set against clamping in an enabled lane, and the R7 flag is checked on both. Operands such as 10 and 3, applied in both orders, make a swapped subtraction show up at once.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
    typedef enum logic [1:0] {
        OP_ADDU = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUBU = 2'b10,
        OP_SUB  = 2'b11
    } sat_op_e;
endpackage

// File: rtl/vsat_lane.sv
module vsat_lane
    import vsat_pkg::*;
#(
    parameter int SEW = 8
) (
    input  logic [SEW-1:0] elem_i,
    input  logic [SEW-1:0] scal_i,
    input  sat_op_e        op_i,
    output logic [SEW-1:0] res_o,
    output logic           clamp_o
);
    localparam int W = SEW + 1;

    localparam logic [SEW-1:0] SMAX = {1'b0, {(SEW-1){1'b1}}};
    localparam logic [SEW-1:0] SMIN = {1'b1, {(SEW-1){1'b0}}};

    logic         is_signed;
    logic         is_sub;
    logic [W-1:0] ext_a;
    logic [W-1:0] ext_b;
    logic [W-1:0] wide;

    always_comb begin
        is_signed = op_i[0];
        is_sub    = op_i[1];
        ext_a     = is_signed ? {elem_i[SEW-1], elem_i} : {1'b0, elem_i};
        ext_b     = is_signed ? {scal_i[SEW-1], scal_i} : {1'b0, scal_i};
        // element first, scalar second
        wide      = is_sub ? (ext_a - ext_b) : (ext_a + ext_b);
        if (is_signed) begin
            clamp_o = wide[W-1] ^ wide[W-2];
            if (clamp_o) res_o = wide[W-1] ? SMIN : SMAX;
            else         res_o = wide[SEW-1:0];
        end else begin
            // carry on add, borrow on subtract
            clamp_o = wide[W-1];
            if (clamp_o) res_o = is_sub ? '0 : '1;
            else         res_o = wide[SEW-1:0];
        end
    end
endmodule

// File: rtl/vsat_merge.sv
module vsat_merge #(
    parameter int SEW   = 8,
    parameter int NELEM = 4
) (
    input  logic [NELEM*SEW-1:0] lane_res_i,
    input  logic [NELEM-1:0]     lane_clamp_i,
    input  logic [NELEM*SEW-1:0] old_i,
    input  logic [NELEM-1:0]     mask_i,
    output logic [NELEM*SEW-1:0] merged_o,
    output logic                 any_clamp_o
);
    for (genvar g = 0; g < NELEM; g++) begin : g_sel
        assign merged_o[g*SEW +: SEW] = mask_i[g] ? lane_res_i[g*SEW +: SEW]
                                                  : old_i[g*SEW +: SEW];
    end

    assign any_clamp_o = |(lane_clamp_i & mask_i);
endmodule

// File: rtl/vsat_addsub.sv
module vsat_addsub
    import vsat_pkg::*;
#(
    parameter int SEW   = 8,
    parameter int NELEM = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NELEM*SEW-1:0] vec_i,
    input  logic [NELEM*SEW-1:0] old_i,
    input  logic [SEW-1:0]       scalar_i,
    input  logic [1:0]           op_i,
    input  logic [NELEM-1:0]     mask_i,
    output logic [NELEM*SEW-1:0] res_o,
    output logic                 sat_o
);
    localparam int VW = NELEM * SEW;

    localparam logic [SEW-1:0] SMAX = {1'b0, {(SEW-1){1'b1}}};
    localparam logic [SEW-1:0] SMIN = {1'b1, {(SEW-1){1'b0}}};

    typedef struct packed {
        logic [VW-1:0] res;
        logic          sat;
    } out_t;

    sat_op_e        op;
    logic [VW-1:0]  lane_res;
    logic [NELEM-1:0] lane_clamp;
    logic [VW-1:0]  merged;
    logic           any_clamp;
    out_t           out_d;
    out_t           out_q;

    assign op = sat_op_e'(op_i);

    for (genvar g = 0; g < NELEM; g++) begin : g_lane
        vsat_lane #(.SEW(SEW)) i_lane (
            .elem_i (vec_i[g*SEW +: SEW]),
            .scal_i (scalar_i),
            .op_i   (op),
            .res_o  (lane_res[g*SEW +: SEW]),
            .clamp_o(lane_clamp[g])
        );
    end

    vsat_merge #(.SEW(SEW), .NELEM(NELEM)) i_merge (
        .lane_res_i  (lane_res),
        .lane_clamp_i(lane_clamp),
        .old_i       (old_i),
        .mask_i      (mask_i),
        .merged_o    (merged),
        .any_clamp_o (any_clamp)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = merged;
        out_d.sat = any_clamp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o = out_q.res;
    assign sat_o = out_q.sat;

    for (genvar g = 0; g < NELEM; g++) begin : g_chk
        // R6
        keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mask_i[g] |=> res_o[g*SEW +: SEW] == $past(old_i[g*SEW +: SEW]));
        // R1
        addu_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 2'b00 && mask_i[g] && lane_clamp[g]) |=> res_o[g*SEW +: SEW] == '1);
        // R3
        subu_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 2'b10 && mask_i[g] && vec_i[g*SEW +: SEW] < scalar_i)
            |=> res_o[g*SEW +: SEW] == '0);
        // R2
        signed_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i[0] && mask_i[g] && lane_clamp[g])
            |=> (res_o[g*SEW +: SEW] == SMAX || res_o[g*SEW +: SEW] == SMIN));
    end

    // R7
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !sat_o);
endmodule

// File: tb/test_vsat_addsub.sv
module test_vsat_addsub;
    localparam int SEW   = 8;
    localparam int NELEM = 4;
    localparam int VW    = SEW * NELEM;
    localparam time PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vec_i = '0;
    logic [VW-1:0] old_i = '0;
    logic [SEW-1:0] scalar_i = '0;
    logic [1:0]    op_i = '0;
    logic [NELEM-1:0] mask_i = '0;
    logic [VW-1:0] res_o;
    logic          sat_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    longint exp_res [NELEM];
    bit     exp_sat;

    always #(PERIOD/2) clk = ~clk;

    vsat_addsub #(.SEW(SEW), .NELEM(NELEM)) i_vsat_addsub (
        .clk(clk), .rst_n(rst_n), .vec_i(vec_i), .old_i(old_i),
        .scalar_i(scalar_i), .op_i(op_i), .mask_i(mask_i),
        .res_o(res_o), .sat_o(sat_o)
    );

    function automatic longint to_s(longint u);
        return (u >= (64'sd1 <<< (SEW-1))) ? u - (64'sd1 <<< SEW) : u;
    endfunction

    // behavioural reference for the inputs currently applied
    task automatic model();
        longint umax = (64'sd1 <<< SEW) - 1;
        longint smax = (64'sd1 <<< (SEW-1)) - 1;
        longint smin = -(64'sd1 <<< (SEW-1));
        longint b = longint'(scalar_i);
        exp_sat = 1'b0;
        for (int i = 0; i < NELEM; i++) begin
            longint a = longint'(vec_i[i*SEW +: SEW]);
            longint r;
            bit c = 1'b0;
            case (op_i)
                2'b00: begin r = a + b; if (r > umax) begin r = umax; c = 1; end end
                2'b10: begin r = a - b; if (r < 0) begin r = 0; c = 1; end end
                default: begin
                    r = (op_i == 2'b01) ? to_s(a) + to_s(b) : to_s(a) - to_s(b);
                    if (r > smax) begin r = smax; c = 1; end
                    if (r < smin) begin r = smin; c = 1; end
                    r = r & umax;
                end
            endcase
            if (mask_i[i]) begin
                exp_res[i] = r;
                exp_sat |= c;
            end else begin
                exp_res[i] = longint'(old_i[i*SEW +: SEW]);
            end
        end
    endtask

    function automatic string op_req(logic [1:0] o);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    // apply at negedge, compare at the following negedge (one register stage, R8)
    task automatic step(logic [VW-1:0] v, logic [VW-1:0] o, logic [SEW-1:0] s,
                        logic [1:0] op, logic [NELEM-1:0] m, string tag);
        vec_i = v; old_i = o; scalar_i = s; op_i = op; mask_i = m;
        model();
        @(negedge clk);
        for (int i = 0; i < NELEM; i++) begin
            compared++;
            if (longint'(res_o[i*SEW +: SEW]) != exp_res[i]) begin
                mismatched++;
                $display("FAIL %s %s lane %0d: got %0d expected %0d",
                         mask_i[i] ? op_req(op_i) : "R6", tag, i,
                         res_o[i*SEW +: SEW], exp_res[i]);
            end
        end
        compared++;
        if (sat_o != exp_sat) begin
            mismatched++;
            $display("FAIL R7 %s: sat got %0b expected %0b", tag, sat_o, exp_sat);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        compared++;
        if (res_o !== '0 || sat_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R8 reset: got %h/%0b expected 0/0", res_o, sat_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 unsigned add edges
        step({8'd255, 8'd200, 8'd100, 8'd0}, '0, 8'd55, 2'b00, 4'hF, "R1 addu");
        step({8'd255, 8'd0, 8'd1, 8'd254}, '0, 8'd1, 2'b00, 4'hF, "R1 addu top");
        // R2 signed add edges
        step({8'h7F, 8'h80, 8'h40, 8'hC0}, '0, 8'h40, 2'b01, 4'hF, "R2 add pos");
        step({8'h7F, 8'h80, 8'h40, 8'hC0}, '0, 8'h80, 2'b01, 4'hF, "R2 add neg");
        // R3 / R5 unsigned subtract and operand order
        step({8'd10, 8'd3, 8'd0, 8'd255}, '0, 8'd3, 2'b10, 4'hF, "R3 R5 subu a");
        step({8'd10, 8'd3, 8'd0, 8'd255}, '0, 8'd10, 2'b10, 4'hF, "R3 R5 subu b");
        // R4 / R5 signed subtract
        step({8'h80, 8'h7F, 8'd10, 8'd3}, '0, 8'h01, 2'b11, 4'hF, "R4 sub");
        step({8'h80, 8'h7F, 8'd10, 8'd3}, '0, 8'hFF, 2'b11, 4'hF, "R4 R5 sub neg");
        // R6 / R7 clamp only in disabled lanes: no flag, old kept
        step({8'd255, 8'd255, 8'd1, 8'd2}, {8'hAA, 8'hBB, 8'hCC, 8'hDD}, 8'd10, 2'b00,
             4'b0011, "R6 R7 masked clamp");
        step({8'd255, 8'd255, 8'd1, 8'd2}, {8'hAA, 8'hBB, 8'hCC, 8'hDD}, 8'd10, 2'b00,
             4'b1000, "R7 enabled clamp");
        step($urandom, {8'h11, 8'h22, 8'h33, 8'h44}, 8'd200, 2'b11, 4'b0000, "R6 all off");

        for (int k = 0; k < 3000; k++)
            step($urandom, $urandom, 8'($urandom), 2'($urandom), 4'($urandom), "random");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule